// File: doc/BRIEF.md
# Source-Selecting Clock Divider with Input-Specific Pre-Scaler

The block derives one output clock from four candidate source clocks. A 32-bit configuration word names the source and two division factors. A prescale factor from 1 to 32 applies only when the highest-numbered source is chosen. A final factor from 1 to 4 applies to every source. Software updates the word through a byte-strobed write port and can read it back at any time. The block also reports the total division ratio that is currently in force.

All logic runs in one fast system clock domain. Each source passes through a synchroniser. The divider counts both rising and falling transitions of the synchronised source. The output toggles once every N transitions, so its period is N source periods and its duty cycle is 50 % for every ratio, odd ones included.

The control FSM has three states. In ST_RUN the divider operates. The transition RUN→STOP is taken at a period boundary (output low and about to rise) when the written source differs from the active one. In ST_STOP the new source and ratio are loaded with the output held low. The transition STOP→ARM is unconditional. ST_ARM waits until the new source's synchronised level is low. The transition ARM→RUN then restarts counting from zero. Reset lands in ST_RUN on source 0 with ratio 1.

Top module: `clksel_prediv`

## Requirements
- R1: The register maps these fields: source select at bits 17:16, prescale code at bits 12:8 and final-divide code at bits 5:4. A read returns the last written value of those bits. Every other bit reads as zero.
- R2: wr_be[k] enables byte k (bits 8k+7:8k) of a write. Bytes whose strobe is clear keep their previous contents. With wr_en low the register does not change.
- R3: After reset the register reads 0, source 0 is active, ratio_o is 1, and clk_o follows source 0.
- R4: ratio_o equals (final code + 1) × P for the active configuration, where P = prescale code + 1 if the active source is 3, and P = 1 otherwise.
- R5: clk_o toggles on every N-th transition (rising or falling) of the synchronised active source, where N = ratio_o. Its period is therefore N source periods. With N = 1 it reproduces the source, delayed by the two synchroniser stages and one output register.
- R6: For sources 0, 1 and 2 the prescale code has no effect on ratio_o or on the clk_o period.
- R7: A new ratio is loaded only at a period boundary, where clk_o is low and about to rise. ratio_o never changes while clk_o is high.
- R8: A source change waits for a period boundary. It then parks clk_o low for one cycle (ST_STOP) and waits in ST_ARM until the new synchronised source is low. Counting then restarts on the new source, and the old source's transitions are ignored.
- R9: clk_o is low in every state other than ST_RUN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the sources |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | 4 | Candidate source clocks, asynchronous |
| wr_en | input | 1 | Register write enable |
| wr_be | input | 4 | Byte strobes for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register contents, unused bits zero |
| clk_o | output | 1 | Divided output clock |
| ratio_o | output | 8 | Total division ratio in force |

## Verification
The assertions take for granted that each source level lasts at least one system clock cycle, so no transition is lost between samples. They also assume reset is held across the first clock edges. The bench derives every source from the system clock with whole-cycle half-periods of 1, 2, 3 and 5 cycles, and changes writes and sources only on the falling system edge. Writes may arrive at any phase of the output. The bench deliberately issues one write while clk_o is high to exercise the deferred reload.

// File: rtl/clksel_pkg.sv
package clksel_pkg;
    localparam int CFG_W     = 32;
    localparam int BYTES     = CFG_W / 8;
    localparam int SEL_LSB   = 16;
    localparam int SEL_W     = 2;
    localparam int PRE_LSB   = 8;
    localparam int PRE_W     = 5;
    localparam int POST_LSB  = 4;
    localparam int POST_W    = 2;
    localparam int NUM_SRC   = 1 << SEL_W;
    localparam int PRE_SRC   = NUM_SRC - 1;
    localparam int RATIO_MAX = (1 << PRE_W) * (1 << POST_W);
    localparam int RATIO_W   = $clog2(RATIO_MAX + 1);
    localparam logic [CFG_W-1:0] CFG_MASK = CFG_W'(
        (((1 << SEL_W) - 1) << SEL_LSB) |
        (((1 << PRE_W) - 1) << PRE_LSB) |
        (((1 << POST_W) - 1) << POST_LSB));

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_STOP = 2'd1,
        ST_ARM  = 2'd2
    } run_state_t;
endpackage

// File: rtl/clksel_sync.sv
module clksel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clksel_cfg_reg.sv
module clksel_cfg_reg
    import clksel_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [BYTES-1:0] wr_be,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg
);
    logic [7:0] byte_q [BYTES];

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                byte_q[b] <= '0;
            else if (wr_en && wr_be[b])
                byte_q[b] <= wr_data[b*8 +: 8] & CFG_MASK[b*8 +: 8];
        end
        assign cfg[b*8 +: 8] = byte_q[b];
    end
endmodule

// File: rtl/clksel_ratio.sv
module clksel_ratio
    import clksel_pkg::*;
(
    input  logic [SEL_W-1:0]   sel,
    input  logic [PRE_W-1:0]   pre,
    input  logic [POST_W-1:0]  post,
    output logic [RATIO_W-1:0] ratio
);
    logic [RATIO_W-1:0] pre_f, post_f;

    always_comb begin
        pre_f  = (sel == SEL_W'(PRE_SRC)) ? RATIO_W'(pre) + RATIO_W'(1)
                                           : RATIO_W'(1);
        post_f = RATIO_W'(post) + RATIO_W'(1);
        ratio  = pre_f * post_f;
    end
endmodule

// File: rtl/clksel_prediv.sv
module clksel_prediv
    import clksel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic               wr_en,
    input  logic [BYTES-1:0]   wr_be,
    input  logic [CFG_W-1:0]   wr_data,
    output logic [CFG_W-1:0]   rd_data,
    output logic               clk_o,
    output logic [RATIO_W-1:0] ratio_o
);
    logic [NUM_SRC-1:0] src_s;
    logic [CFG_W-1:0]   cfg_q;
    logic [SEL_W-1:0]   req_sel, act_sel_q, ratio_sel;
    logic [PRE_W-1:0]   req_pre;
    logic [POST_W-1:0]  req_post;
    logic [RATIO_W-1:0] ratio_q, cnt_q, ratio_new;
    logic               out_q, lvl_q, lvl_now, edge_seen, last_edge;
    logic               boundary, switch_req;
    run_state_t         state_q, state_d;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_sync
        clksel_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (src_clk[gi]),
            .q     (src_s[gi])
        );
    end

    clksel_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .cfg     (cfg_q)
    );

    assign req_sel  = cfg_q[SEL_LSB  +: SEL_W];
    assign req_pre  = cfg_q[PRE_LSB  +: PRE_W];
    assign req_post = cfg_q[POST_LSB +: POST_W];

    // In STOP the incoming source decides whether the prescaler counts.
    assign ratio_sel = (state_q == ST_STOP) ? req_sel : act_sel_q;

    clksel_ratio u_ratio (
        .sel   (ratio_sel),
        .pre   (req_pre),
        .post  (req_post),
        .ratio (ratio_new)
    );

    assign lvl_now    = src_s[act_sel_q];
    assign edge_seen  = lvl_now ^ lvl_q;
    assign last_edge  = edge_seen && (cnt_q == ratio_q - 1'b1);
    assign boundary   = last_edge && !out_q;
    assign switch_req = (req_sel != act_sel_q);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (boundary && switch_req) state_d = ST_STOP;
            ST_STOP: state_d = ST_ARM;
            ST_ARM:  if (!lvl_now) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_sel_q <= '0;
            ratio_q   <= RATIO_W'(1);
            cnt_q     <= '0;
            out_q     <= 1'b0;
            lvl_q     <= 1'b0;
        end else begin
            lvl_q <= lvl_now;
            unique case (state_q)
                ST_RUN: begin
                    if (edge_seen) begin
                        if (!last_edge) begin
                            cnt_q <= cnt_q + 1'b1;
                        end else begin
                            cnt_q <= '0;
                            if (out_q) begin
                                out_q <= 1'b0;
                            end else if (!switch_req) begin
                                out_q   <= 1'b1;
                                ratio_q <= ratio_new;
                            end
                        end
                    end
                end
                ST_STOP: begin
                    act_sel_q <= req_sel;
                    ratio_q   <= ratio_new;
                    out_q     <= 1'b0;
                end
                ST_ARM:  cnt_q <= '0;
                default: cnt_q <= '0;
            endcase
        end
    end

    assign rd_data = cfg_q;
    assign clk_o   = out_q;
    assign ratio_o = ratio_q;
endmodule

// File: rtl/clksel_prediv_chk.sv
module clksel_prediv_chk
    import clksel_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [BYTES-1:0]   wr_be,
    input logic [CFG_W-1:0]   wr_data,
    input logic [CFG_W-1:0]   rd_data,
    input logic               clk_o,
    input logic [RATIO_W-1:0] ratio_o,
    input run_state_t         state
);
    // R1
    a_r1_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (&wr_be)) |=> rd_data == ($past(wr_data) & CFG_MASK));

    // R2
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data));

    // R4
    a_r4_ratio_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_o != '0) && (ratio_o <= RATIO_W'(RATIO_MAX)));

    // R7
    a_r7_reload_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio_o) |-> !$past(clk_o));

    // R8
    a_r8_stop_to_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STOP) |=> (state == ST_ARM));

    // R9
    a_r9_parked_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> !clk_o);
endmodule

bind clksel_prediv clksel_prediv_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_be   (wr_be),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .clk_o   (clk_o),
    .ratio_o (ratio_o),
    .state   (state_q)
);

// File: tb/tb_clksel_prediv.sv
module tb_clksel_prediv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src = 4'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'b0;
    logic [31:0] wr_data = 32'b0;
    logic [31:0] rd_data;
    logic        clk_o;
    logic [7:0]  ratio_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;

    always #2 clk = ~clk;

    clksel_prediv dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_clk (src),
        .wr_en   (wr_en),
        .wr_be   (wr_be),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .clk_o   (clk_o),
        .ratio_o (ratio_o)
    );

    // Source half-periods in system cycles
    int hp[4] = '{3, 5, 2, 1};
    int src_cnt[4] = '{0, 0, 0, 0};

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            if (src_cnt[i] == hp[i] - 1) begin
                src_cnt[i] <= 0;
                src[i] <= ~src[i];
            end else begin
                src_cnt[i] <= src_cnt[i] + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Behavioural reference model, stepped once per system clock
    bit m_s1[4] = '{0, 0, 0, 0};
    bit m_s2[4] = '{0, 0, 0, 0};
    bit m_lvl = 0, m_out = 0, m_now = 0;
    int m_cnt = 0, m_n = 1, m_sel = 0, m_state = 0, m_rs = 0;
    logic [31:0] m_reg = 32'h0;

    function automatic int f_ratio(input int sel, input logic [31:0] r);
        int p;
        p = (sel == 3) ? int'(r[12:8]) + 1 : 1;
        return p * (int'(r[5:4]) + 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin
                m_s1[i] = 0;
                m_s2[i] = 0;
            end
            m_lvl = 0; m_out = 0; m_cnt = 0; m_n = 1;
            m_sel = 0; m_state = 0; m_reg = 32'h0;
        end else begin
            m_now = m_s2[m_sel];
            m_rs  = int'(m_reg[17:16]);
            case (m_state)
                0: if (m_now != m_lvl) begin
                    if (m_cnt == m_n - 1) begin
                        m_cnt = 0;
                        if (m_out) m_out = 0;
                        else if (m_rs != m_sel) m_state = 1;
                        else begin
                            m_out = 1;
                            m_n = f_ratio(m_sel, m_reg);
                        end
                    end else begin
                        m_cnt++;
                    end
                end
                1: begin
                    m_sel = m_rs;
                    m_n = f_ratio(m_rs, m_reg);
                    m_out = 0;
                    m_state = 2;
                end
                default: begin
                    m_cnt = 0;
                    if (!m_now) m_state = 0;
                end
            endcase
            m_lvl = m_now;
            for (int i = 0; i < 4; i++) begin
                m_s2[i] = m_s1[i];
                m_s1[i] = src[i];
            end
            for (int b = 0; b < 4; b++)
                if (wr_en && wr_be[b])
                    m_reg[b*8 +: 8] = wr_data[b*8 +: 8] & (32'h0003_1F30 >> (b*8));
        end
    end

    // Per-cycle comparison and output period tracking
    bit prev_o = 0;
    int prev_ratio = 1;
    int last_rise = -1, last_per = 0, rise_cnt = 0, hi_reload = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk(clk_o == m_out, "R5/R8 clk_o vs model", clk_o, m_out);
            chk(ratio_o == m_n, "R4/R7 ratio_o vs model", ratio_o, m_n);
            chk(rd_data == m_reg, "R1/R2 rd_data vs model", rd_data, m_reg);
            if (m_state != 0) chk(!clk_o, "R9 clk_o low while parked", clk_o, 0);
            if (int'(ratio_o) != prev_ratio && prev_o) hi_reload++;
            if (clk_o && !prev_o) begin
                if (last_rise >= 0) last_per = cyc - last_rise;
                last_rise = cyc;
                rise_cnt++;
            end
            prev_o = clk_o;
            prev_ratio = int'(ratio_o);
        end
        if (cyc > 150000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary();
            $finish;
        end
    end

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0; wr_data = 32'h0;
    endtask

    task automatic wait_ratio(input int exp, input string tag);
        int k;
        k = 0;
        while (int'(ratio_o) != exp && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk(int'(ratio_o) == exp, tag, ratio_o, exp);
    endtask

    task automatic meas(input int exp, input string tag);
        int r0, k;
        r0 = rise_cnt;
        k = 0;
        while (rise_cnt < r0 + 3 && k < 5000) begin
            @(negedge clk);
            k++;
        end
        chk(last_per == exp, tag, last_per, exp);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 32'h0, "R3 register after reset", rd_data, 0);
        chk(ratio_o == 8'd1, "R3 ratio after reset", ratio_o, 1);
        meas(6, "R3 source 0 passed through");

        wr(4'hF, 32'hFFFF_FFFF);
        chk(rd_data == 32'h0003_1F30, "R1 only mapped bits stored", rd_data, 32'h0003_1F30);
        wait_ratio(128, "R4 prescaled ratio on source 3");
        meas(256, "R6 prescaler active on source 3");

        while (!clk_o) @(negedge clk);
        wr(4'h1, 32'h0);
        chk(ratio_o == 8'd128, "R7 ratio held during high phase", ratio_o, 128);
        chk(rd_data == 32'h0003_1F00, "R2 byte 0 only", rd_data, 32'h0003_1F00);
        wait_ratio(32, "R4 final code cleared");
        meas(64, "R5 period for ratio 32");

        wr(4'h4, 32'h0001_0000);
        chk(rd_data == 32'h0001_1F00, "R2 byte 2 only", rd_data, 32'h0001_1F00);
        wait_ratio(1, "R6 prescale ignored on source 1");
        meas(10, "R8 counting on new source 1");

        wr(4'h1, 32'h0000_0020);
        wait_ratio(3, "R4 odd ratio");
        meas(30, "R5 odd ratio period");

        wr(4'h5, 32'h0002_0030);
        chk(rd_data == 32'h0002_1F30, "R2 bytes 0 and 2", rd_data, 32'h0002_1F30);
        wait_ratio(4, "R6 prescale ignored on source 2");
        meas(16, "R6 source 2 period");

        wr(4'hF, 32'h0003_0410);
        wait_ratio(10, "R4 prescale 5 times final 2");
        meas(20, "R5 period for ratio 10");

        wr(4'hF, ~32'h0003_1F30);
        chk(rd_data == 32'h0, "R1 unused bits read zero", rd_data, 0);
        wait_ratio(1, "R8 back to source 0");
        meas(6, "R5 pass-through on source 0");

        chk(hi_reload == 0, "R7 reloads seen with clk_o high", hi_reload, 0);
        done = 1;
        summary();
        $finish;
    end
endmodule